// File: doc/BRIEF.md
# Serial Channel Pin Multiplexer

This block sits between two 8-bit general-purpose I/O ports and the pads they drive. It lets up to four clocked or asynchronous serial channels take over groups of four pins each, and lets two DMA handshake channels take over the upper half of the first port. Three small configuration registers, written over a simple register bus, decide who owns each pin. The transfer mode of each serial channel decides which way its clock and ready pins point.

Software first sets the transfer mode of a channel and then sets the select bits of the pins that channel needs. Pins that are not selected stay under the control of the general-purpose port logic. The configuration survives a hot reset, so pins keep their function across a warm restart. A cold reset returns every pin to plain port use.

Top module: `serpin_mux`

## Requirements
- R1: While `cold_rst_n` is low, and after it, until the next write, every configuration register reads 0. Every pad then follows `gpioA_out`/`gpioA_oe` and `gpioB_out`/`gpioB_oe`.
- R2: While `hot_rst_n` is low, register writes are ignored and all configuration registers keep their previous values.
- R3: The register map is as follows. Address 0 is the select byte of port A. Address 1 is the select byte of port B. Address 2 holds the four DMA override bits in data bits 7:4 and reads 0 in bits 3:0. Address 3 reads 0 and ignores writes. A write is visible on `reg_rdata` after the next rising clock edge.
- R4: A pin whose select bit is 0 drives `pad_out`/`pad_oe` from the matching GPIO output and enable.
- R5: Channel c uses port A for c in 0–1 and port B for c in 2–3, at bits 4*(c%2)+k. Here k is 0 for data in, 1 for data out, 2 for clock and 3 for ready.
- R6: A selected data-in pin has its output enable low. A selected data-out pin has its output enable high and drives `ser_dout[c]`, in every mode.
- R7: The mode code is 2 bits per channel in `ch_mode[2c+1:2c]`: 0 clocked master, 1 clocked slave, 2 async internal clock, 3 async external clock. A selected clock pin drives `ser_clk_out[c]` in mode 0. It is an input in modes 1 and 3, and falls back to GPIO control in mode 2.
- R8: A selected ready pin drives `ser_rdy_out[c]` in mode 1. It is an input in mode 0, and falls back to GPIO control in modes 2 and 3.
- R9: If port-A bit 4+j has both its select bit and override bit j set, the pin drives a DMA handshake with its output enable high. This takes priority over the serial function. Bits 4, 5, 6 and 7 carry `dma_ack_n[0]`, `dma_end_n[0]`, `dma_ack_n[1]` and `dma_end_n[1]`. An override bit with its select bit at 0 leaves the pin on GPIO.
- R10: `gpioA_in`, `gpioB_in` and `ser_din` always follow the pads. `ser_clk_in[c]` and `ser_rdy_in[c]` follow their pad only while that pin is serially owned as an input (R7, R8, not overridden by R9), and are 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low, clears configuration |
| hot_rst_n | input | 1 | Hot reset, active low, holds configuration |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ch_mode | input | 8 | Transfer mode, 2 bits per channel |
| ser_dout | input | 4 | Serial data out per channel |
| ser_clk_out | input | 4 | Master clock per channel |
| ser_rdy_out | input | 4 | Slave ready per channel |
| ser_din | output | 4 | Serial data in per channel |
| ser_clk_in | output | 4 | Slave/external clock in per channel, idle 1 |
| ser_rdy_in | output | 4 | Master ready in per channel, idle 1 |
| dma_ack_n | input | 2 | DMA acknowledge per DMA channel |
| dma_end_n | input | 2 | DMA end per DMA channel |
| gpioA_out | input | 8 | Port A GPIO output data |
| gpioA_oe | input | 8 | Port A GPIO output enable |
| gpioA_in | output | 8 | Port A pad input to GPIO |
| gpioB_out | input | 8 | Port B GPIO output data |
| gpioB_oe | input | 8 | Port B GPIO output enable |
| gpioB_in | output | 8 | Port B pad input to GPIO |
| padA_in | input | 8 | Port A pad input |
| padA_out | output | 8 | Port A pad output |
| padA_oe | output | 8 | Port A pad output enable |
| padB_in | input | 8 | Port B pad input |
| padB_out | output | 8 | Port B pad output |
| padB_oe | output | 8 | Port B pad output enable |

## Verification
The embedded assertions check four things on every cycle. Data pins keep their fixed direction. An active DMA override always enables its pad. Clock and ready inputs idle high when their pin is not serially owned. The registers hold through a hot reset. Only the bench sweep can show that each of the 256 mode combinations gives the right clock and ready direction, across select and override patterns, with the correct pad routing for every pin. The same holds for the register map and for the difference between cold and hot reset.

// File: rtl/serpin_mux.sv
module serpin_mux #(
  parameter int NCH = 4
) (
  input  logic       clk,
  input  logic       cold_rst_n,
  input  logic       hot_rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [7:0] ch_mode,
  input  logic [3:0] ser_dout,
  input  logic [3:0] ser_clk_out,
  input  logic [3:0] ser_rdy_out,
  output logic [3:0] ser_din,
  output logic [3:0] ser_clk_in,
  output logic [3:0] ser_rdy_in,
  input  logic [1:0] dma_ack_n,
  input  logic [1:0] dma_end_n,
  input  logic [7:0] gpioA_out,
  input  logic [7:0] gpioA_oe,
  output logic [7:0] gpioA_in,
  input  logic [7:0] gpioB_out,
  input  logic [7:0] gpioB_oe,
  output logic [7:0] gpioB_in,
  input  logic [7:0] padA_in,
  output logic [7:0] padA_out,
  output logic [7:0] padA_oe,
  input  logic [7:0] padB_in,
  output logic [7:0] padB_out,
  output logic [7:0] padB_oe
);
  localparam int NPIN = NCH * 4;
  localparam logic [1:0] M_MST = 2'd0, M_SLV = 2'd1, M_AINT = 2'd2, M_AEXT = 2'd3;

  logic [7:0] sel_a, sel_b;
  logic [3:0] dma_ovr;
  logic       wr_ok;

  assign wr_ok = reg_we && hot_rst_n;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      sel_a   <= '0;
      sel_b   <= '0;
      dma_ovr <= '0;
    end else if (wr_ok) begin
      case (reg_addr)
        2'd0: sel_a   <= reg_wdata;
        2'd1: sel_b   <= reg_wdata;
        2'd2: dma_ovr <= reg_wdata[7:4];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = sel_a;
      2'd1:    reg_rdata = sel_b;
      2'd2:    reg_rdata = {dma_ovr, 4'b0000};
      default: reg_rdata = '0;
    endcase
  end

  logic [NPIN-1:0] sel_all, pin_in, gp_out, gp_oe, pin_out, pin_oe;
  logic [NPIN-1:0] live_in;
  logic [3:0]      dma_sig;

  assign sel_all  = {sel_b, sel_a};
  assign pin_in   = {padB_in, padA_in};
  assign gp_out   = {gpioB_out, gpioA_out};
  assign gp_oe    = {gpioB_oe, gpioA_oe};
  assign dma_sig  = {dma_end_n[1], dma_ack_n[1], dma_end_n[0], dma_ack_n[0]};
  assign padA_out = pin_out[7:0];
  assign padB_out = pin_out[15:8];
  assign padA_oe  = pin_oe[7:0];
  assign padB_oe  = pin_oe[15:8];
  assign gpioA_in = padA_in;
  assign gpioB_in = padB_in;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    localparam int CH   = i / 4;
    localparam int ROLE = i % 4;
    localparam bit DPIN = (i >= 4) && (i < 8);
    logic       own, dma, o, e, live;
    logic [1:0] md;
    assign md  = ch_mode[2*CH +: 2];
    assign own = sel_all[i];
    assign dma = DPIN && own && dma_ovr[i % 4];
    always_comb begin
      o    = gp_out[i];
      e    = gp_oe[i];
      live = 1'b0;
      if (dma) begin
        o = dma_sig[i % 4];
        e = 1'b1;
      end else if (own) begin
        case (ROLE)
          0: begin o = 1'b0; e = 1'b0; end
          1: begin o = ser_dout[CH]; e = 1'b1; end
          2: case (md)
               M_MST:          begin o = ser_clk_out[CH]; e = 1'b1; end
               M_SLV, M_AEXT:  begin o = 1'b0; e = 1'b0; live = 1'b1; end
               default: ;
             endcase
          default: case (md)
               M_SLV: begin o = ser_rdy_out[CH]; e = 1'b1; end
               M_MST: begin o = 1'b0; e = 1'b0; live = 1'b1; end
               default: ;
             endcase
        endcase
      end
    end
    assign pin_out[i] = o;
    assign pin_oe[i]  = e;
    assign live_in[i] = live;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ser_din[c]    = pin_in[4*c];
    assign ser_clk_in[c] = live_in[4*c+2] ? pin_in[4*c+2] : 1'b1;
    assign ser_rdy_in[c] = live_in[4*c+3] ? pin_in[4*c+3] : 1'b1;
  end

  // R6
  din_dir_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (sel_a[0] && !pin_oe[0] && sel_b[4]) |-> !padB_oe[4]);
  // R6
  dout_dir_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (sel_a[1] && sel_b[1] && sel_b[5]) |-> (padA_oe[1] && padB_oe[1] && padB_oe[5]));
  // R9
  dma_oe_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((sel_a[7:4] & dma_ovr) != 4'b0) |-> ((padA_oe[7:4] & sel_a[7:4] & dma_ovr) == (sel_a[7:4] & dma_ovr)));
  // R10
  idle_in_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    ((sel_all[2] == 1'b0) && (sel_all[3] == 1'b0)) |-> (ser_clk_in[0] && ser_rdy_in[0]));
  // R2
  hot_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !hot_rst_n |=> ($stable(sel_a) && $stable(sel_b) && $stable(dma_ovr)));
  // R1
  cold_clear_chk: assert property (@(posedge clk)
    !cold_rst_n |-> (reg_rdata == 8'h00));
endmodule

// File: tb/serpin_mux_bench.sv
module serpin_mux_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, cold_rst_n = 0, hot_rst_n = 1, reg_we = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata, ch_mode = 0;
  logic [3:0] ser_dout = 0, ser_clk_out = 0, ser_rdy_out = 0, ser_din, ser_clk_in, ser_rdy_in;
  logic [1:0] dma_ack_n = 0, dma_end_n = 0;
  logic [7:0] gpioA_out = 0, gpioA_oe = 0, gpioA_in, gpioB_out = 0, gpioB_oe = 0, gpioB_in;
  logic [7:0] padA_in = 0, padA_out, padA_oe, padB_in = 0, padB_out, padB_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serpin_mux u_serpin_mux (.*);

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    reg_we = 1; reg_addr = a[1:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(string req, int a, int exp);
    reg_addr = a[1:0];
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic sweep_check(int sa, int sb, int ov);
    logic [15:0] sel, pin, gpo, gpe;
    logic [3:0]  dsig;
    logic [3:0]  eck, erd;
    sel  = {sb[7:0], sa[7:0]};
    pin  = {padB_in, padA_in};
    gpo  = {gpioB_out, gpioA_out};
    gpe  = {gpioB_oe, gpioA_oe};
    dsig = {dma_end_n[1], dma_ack_n[1], dma_end_n[0], dma_ack_n[0]};
    eck  = 4'hF; erd = 4'hF;
    for (int i = 0; i < 16; i++) begin
      int c = i / 4, k = i % 4, m;
      bit eo, ee, isdma, ao, ae;
      string rq;
      m = (ch_mode >> (2*c)) & 3;
      isdma = (i >= 4 && i < 8) && sel[i] && ov[i-4];
      eo = gpo[i]; ee = gpe[i]; rq = "R4";
      if (isdma) begin eo = dsig[i-4]; ee = 1; rq = "R9"; end
      else if (sel[i]) begin
        if (k == 0) begin ee = 0; rq = "R6"; end
        else if (k == 1) begin eo = ser_dout[c]; ee = 1; rq = "R6"; end
        else if (k == 2) begin
          rq = "R7";
          if (m == 0) begin eo = ser_clk_out[c]; ee = 1; end
          else if (m != 2) begin ee = 0; eck[c] = pin[i]; end
        end else begin
          rq = "R8";
          if (m == 1) begin eo = ser_rdy_out[c]; ee = 1; end
          else if (m == 0) begin ee = 0; erd[c] = pin[i]; end
        end
      end
      ao = (i < 8) ? padA_out[i] : padB_out[i-8];
      ae = (i < 8) ? padA_oe[i] : padB_oe[i-8];
      check(rq, ae, ee);
      if (ee) check(rq, ao, eo);
    end
    check("R10", ser_clk_in, eck);
    check("R10", ser_rdy_in, erd);
    check("R10", ser_din, {pin[12], pin[8], pin[4], pin[0]});
    check("R10", {gpioB_in, gpioA_in}, pin);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: cleared during cold reset
    rd_chk("R1", 0, 0); rd_chk("R1", 1, 0); rd_chk("R1", 2, 0);
    cold_rst_n = 1;
    gpioA_out = 8'h5A; gpioA_oe = 8'hC3; gpioB_out = 8'h96; gpioB_oe = 8'h0F;
    #1;
    check("R1", {padB_out, padA_out}, 16'h965A);
    check("R1", {padB_oe, padA_oe}, 16'h0FC3);
    // R3 map
    wr(0, 8'hA5); wr(1, 8'h3C); wr(2, 8'hFF); wr(3, 8'h77);
    rd_chk("R3", 0, 8'hA5); rd_chk("R3", 1, 8'h3C);
    rd_chk("R3", 2, 8'hF0); rd_chk("R3", 3, 8'h00);
    // R2 hot reset holds, writes ignored
    @(negedge clk); hot_rst_n = 0;
    wr(0, 8'h11); wr(1, 8'h22); wr(2, 8'h00);
    @(negedge clk); hot_rst_n = 1;
    rd_chk("R2", 0, 8'hA5); rd_chk("R2", 1, 8'h3C); rd_chk("R2", 2, 8'hF0);
    // R1 cold reset clears
    @(negedge clk); cold_rst_n = 0;
    @(negedge clk); cold_rst_n = 1;
    rd_chk("R1", 0, 0); rd_chk("R1", 1, 0); rd_chk("R1", 2, 0);
    // R5..R10 sweep: all mode combinations x select/override patterns
    for (int mv = 0; mv < 256; mv++) begin
      for (int p = 0; p < 9; p++) begin
        int sa, sb, ov, s;
        s  = mv * 9 + p;
        sa = (p % 3 == 0) ? 8'hFF : (p % 3 == 1) ? 8'h5A : 8'h00;
        sb = (p % 3 == 0) ? 8'hFF : (p % 3 == 1) ? 8'hC3 : 8'hFF;
        ov = (p / 3 == 0) ? 0 : (p / 3 == 1) ? 4'hF : 4'h5;
        ch_mode = mv[7:0];
        padA_in = 8'(s * 29 + 7); padB_in = 8'(s * 53 + 3);
        gpioA_out = 8'(s * 11); gpioA_oe = 8'(s * 17 + 1);
        gpioB_out = 8'(s * 13 + 5); gpioB_oe = 8'(s * 19);
        ser_dout = 4'(s); ser_clk_out = 4'(s * 3 + 1); ser_rdy_out = 4'(s * 7 + 2);
        dma_ack_n = 2'(s); dma_end_n = 2'(s >> 2);
        wr(0, sa); wr(1, sb); wr(2, ov << 4);
        #1;
        sweep_check(sa, sb, ov);
      end
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule